// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Counters

This block predicts the next fetch address for a 32-bit, five-stage pipeline whose branches resolve in the decode stage. The fetch stage presents its current PC and gets back a hit flag, a taken prediction and the predicted next PC in the same cycle. When a branch reaches decode, the stage presents the branch PC, a branch qualifier, the taken outcome and the computed target. The block then raises a combinational redirect, carrying the correct next PC, whenever the fetch stream that followed the branch was wrong. It also writes the entry for that branch at the next clock edge.

The table is direct-mapped. Each slot holds a valid bit, a tag, a full byte-address target and a two-bit saturating counter. Branches enter the table whether they go taken or not. The counter is seeded from the first outcome, so the state recorded for a branch builds up on the first resolve.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is invalid, so every lookup reports no hit, no taken prediction and a next PC of fetch PC + 4.
- R2: The slot is chosen by PC bits [INDEX_BITS+1:2] (default INDEX_BITS = 8, legal range 4 to 9). The tag is PC bits [31:INDEX_BITS+2]. PC bits [1:0] take no part in the lookup. A hit needs a valid slot whose tag matches.
- R3: On a hit whose counter has bit 1 set, the lookup predicts taken and gives the stored target. In every other case it predicts not taken and gives fetch PC + 4.
- R4: A taken branch that misses raises redirect with the computed target, and allocates its slot with counter 2'b10.
- R5: A not-taken branch that misses raises no redirect, and allocates its slot with counter 2'b01.
- R6: On a hit, a taken outcome increments the counter, saturating at 3. A not-taken outcome decrements it, saturating at 0.
- R7: On a hit, the stored target is replaced by the computed target of the resolving branch.
- R8: On a hit, redirect is raised exactly when the predicted next PC differs from the resolved next PC. The resolved next PC is the target if taken, else branch PC + 4, and redirect_pc carries that value.
- R9: A resolve with the branch qualifier low raises no redirect and leaves the table unchanged.
- R10: An allocation replaces whatever valid entry occupied the indexed slot.
- R11: A lookup in the same cycle as an update to the same slot sees the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all valid bits |
| fetch_pc | input | 32 | PC being fetched |
| pred_hit | output | 1 | Lookup found a matching valid slot |
| pred_taken | output | 1 | Lookup predicts taken |
| pred_npc | output | 32 | Predicted next fetch PC |
| res_is_branch | input | 1 | Instruction in decode is a branch; qualifies the resolve inputs |
| res_pc | input | 32 | PC of the resolving instruction |
| res_taken | input | 1 | Branch outcome |
| res_target | input | 32 | Computed branch target |
| redirect | output | 1 | Flush younger instructions and restart fetch |
| redirect_pc | output | 32 | Address to restart fetch at |

## Verification
The assertions assume that res_pc, res_taken and res_target are meaningful only while res_is_branch is high. They also assume that a hit on res_pc really is a branch, because only branches are ever written. The bench raises res_is_branch for one cycle per resolve and drops it between resolves. It resolves only addresses it treats as branches, except in the one resolve that checks a non-branch is ignored. The one-cycle allocation check compares only word addresses, which matches the lookup ignoring PC bits [1:0].

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int INDEX_BITS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] fetch_pc,
  output logic        pred_hit,
  output logic        pred_taken,
  output logic [31:0] pred_npc,
  input  logic        res_is_branch,
  input  logic [31:0] res_pc,
  input  logic        res_taken,
  input  logic [31:0] res_target,
  output logic        redirect,
  output logic [31:0] redirect_pc
);
  localparam int ENTRIES = 1 << INDEX_BITS;
  localparam int TAG_W   = 30 - INDEX_BITS;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [31:0]        tgt_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];

  wire [INDEX_BITS-1:0] f_idx = fetch_pc[INDEX_BITS+1:2];
  wire [TAG_W-1:0]      f_tag = fetch_pc[31:INDEX_BITS+2];
  wire [INDEX_BITS-1:0] r_idx = res_pc[INDEX_BITS+1:2];
  wire [TAG_W-1:0]      r_tag = res_pc[31:INDEX_BITS+2];

  assign pred_hit   = valid_q[f_idx] && (tag_q[f_idx] == f_tag);
  assign pred_taken = pred_hit && ctr_q[f_idx][1];
  assign pred_npc   = pred_taken ? tgt_q[f_idx] : fetch_pc + 32'd4;

  wire        r_hit   = valid_q[r_idx] && (tag_q[r_idx] == r_tag);
  wire [1:0]  r_ctr   = ctr_q[r_idx];
  wire [31:0] r_seq   = res_pc + 32'd4;
  wire [31:0] r_guess = (r_hit && r_ctr[1]) ? tgt_q[r_idx] : r_seq;
  wire [31:0] r_true  = res_taken ? res_target : r_seq;

  logic [1:0] r_ctr_nx;
  always_comb begin
    if (!r_hit)         r_ctr_nx = res_taken ? 2'b10 : 2'b01;
    else if (res_taken) r_ctr_nx = (r_ctr == 2'd3) ? 2'd3 : r_ctr + 2'd1;
    else                r_ctr_nx = (r_ctr == 2'd0) ? 2'd0 : r_ctr - 2'd1;
  end

  assign redirect    = res_is_branch && (r_hit ? (r_guess != r_true) : res_taken);
  assign redirect_pc = r_true;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             valid_q <= '0;
    else if (res_is_branch) valid_q[r_idx] <= 1'b1;

  always_ff @(posedge clk)
    if (res_is_branch) begin
      tag_q[r_idx] <= r_tag;
      tgt_q[r_idx] <= res_target;
      ctr_q[r_idx] <= r_ctr_nx;
    end

  // R9
  redirect_needs_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> res_is_branch);
  // R3
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> pred_hit);
  // R4
  taken_miss_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_is_branch && res_taken && !r_hit) |-> (redirect && redirect_pc == res_target));
  // R5
  nt_miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_is_branch && !res_taken && !r_hit) |-> !redirect);
  // R10
  alloc_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_is_branch |=> ((fetch_pc[31:2] != $past(res_pc[31:2])) || pred_hit));
  // R6
  ctr_sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_is_branch && r_hit && res_taken && r_ctr == 2'd3) |=> (ctr_q[$past(r_idx)] == 2'd3));
endmodule

// File: tb/btb_predictor_tb.sv
module btb_predictor_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit, pred_taken, redirect;
  logic [31:0] pred_npc, redirect_pc;
  logic        res_is_branch = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0;
  logic [31:0] res_target = '0;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] PA = 32'h0000_1040;
  localparam logic [31:0] PB = 32'h0000_1100;
  localparam logic [31:0] PC = 32'h1230_0200;
  localparam logic [31:0] PD = 32'h0004_1040;
  localparam logic [31:0] TA = 32'h0000_2000;
  localparam logic [31:0] T2 = 32'h0000_3000;
  localparam logic [31:0] TB = 32'h0000_5000;

  btb_predictor u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_npc(pred_npc),
    .res_is_branch(res_is_branch), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .redirect(redirect), .redirect_pc(redirect_pc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] pc, input bit hit, input bit tk,
                      input logic [31:0] npc, input string req);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    chk(pred_hit == hit, req, "pred_hit", {31'd0, pred_hit}, {31'd0, hit});
    chk(pred_taken == tk, req, "pred_taken", {31'd0, pred_taken}, {31'd0, tk});
    chk(pred_npc == npc, req, "pred_npc", pred_npc, npc);
  endtask

  task automatic resolve(input logic [31:0] pc, input bit br, input bit tk,
                         input logic [31:0] tgt, input bit exp_r,
                         input logic [31:0] exp_pc, input string req);
    @(negedge clk);
    res_pc = pc; res_is_branch = br; res_taken = tk; res_target = tgt;
    #1;
    chk(redirect == exp_r, req, "redirect", {31'd0, redirect}, {31'd0, exp_r});
    if (exp_r) chk(redirect_pc == exp_pc, req, "redirect_pc", redirect_pc, exp_pc);
    @(posedge clk);
    #1 res_is_branch = 1'b0;
  endtask

  task automatic t_reset();
    look(PA, 0, 0, PA + 4, "R1");
    look(PC, 0, 0, PC + 4, "R1");
  endtask

  task automatic t_taken_miss();
    resolve(PA, 1, 1, TA, 1, TA, "R4");
    look(PA, 1, 1, TA, "R4");
    look(PA | 32'd1, 1, 1, TA, "R2");
  endtask

  task automatic t_nt_miss();
    resolve(PB, 1, 0, TB, 0, 0, "R5");
    look(PB, 1, 0, PB + 4, "R5");
  endtask

  task automatic t_counter();
    resolve(PA, 1, 0, TA, 1, PA + 4, "R8");
    look(PA, 1, 0, PA + 4, "R6");
    resolve(PA, 1, 1, TA, 1, TA, "R8");
    resolve(PA, 1, 1, TA, 0, 0, "R6");
    resolve(PA, 1, 1, TA, 0, 0, "R6");
    resolve(PA, 1, 0, TA, 1, PA + 4, "R8");
    look(PA, 1, 1, TA, "R6");
    resolve(PB, 1, 0, TB, 0, 0, "R6");
    resolve(PB, 1, 0, TB, 0, 0, "R6");
    resolve(PB, 1, 1, TB, 1, TB, "R8");
    look(PB, 1, 0, PB + 4, "R6");
  endtask

  task automatic t_retarget();
    resolve(PA, 1, 1, T2, 1, T2, "R7");
    look(PA, 1, 1, T2, "R7");
  endtask

  task automatic t_nonbranch();
    resolve(PC, 0, 1, TA, 0, 0, "R9");
    look(PC, 0, 0, PC + 4, "R9");
  endtask

  task automatic t_overwrite();
    resolve(PD, 1, 1, TA, 1, TA, "R10");
    look(PD, 1, 1, TA, "R10");
    look(PA, 0, 0, PA + 4, "R10");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    fetch_pc = PD;
    res_pc = PD; res_is_branch = 1'b1; res_taken = 1'b0; res_target = TA;
    #1;
    chk(pred_taken == 1'b1, "R11", "pred_taken old", {31'd0, pred_taken}, 32'd1);
    chk(pred_npc == TA, "R11", "pred_npc old", pred_npc, TA);
    chk(redirect == 1'b1, "R8", "redirect", {31'd0, redirect}, 32'd1);
    @(posedge clk);
    #1 res_is_branch = 1'b0;
    look(PD, 1, 0, PD + 4, "R11");
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_taken_miss();
    t_nt_miss();
    t_counter();
    t_retarget();
    t_nonbranch();
    t_overwrite();
    t_same_cycle();
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule